// File: doc/BRIEF.md
# Ordered Read/Write Request Bridge to a Non-Stallable Memory Port

The bridge sits between a TileLink-UL manager port (A request channel, D response channel) and a simple memory controller. The controller takes requests through a valid/ready handshake. It returns read data through a port that has only a valid strobe and no ready. Each A-channel request is one beat of at most 32 bytes. Its beat-relative address, byte mask and data go to the memory request port unchanged. Get is issued as a read and PutFullData as a write.

The memory never reports which request a read answer belongs to, so the bridge keeps its own record of every request it accepts. One ordered tag queue holds the request kind, source ID and size. Returned read data lands in a separate buffer and is paired with the oldest tag. The memory cannot be stalled, so the bridge counts reads that are in flight or buffered. It turns away a further Get whenever that count has reached the buffer depth. Writes are acknowledged from the tag queue as soon as they reach its head, which keeps reads and writes in one response order.

Back-pressure rules: A-channel ready never depends on D-channel ready, and memory request valid never depends on memory request ready. D-channel valid, once raised, is held with all response fields stable until d_ready is seen high. The unused B, C and E channels are tied off.

Top module: `tl_mem_bridge`

## Requirements
- R1: While a request is admitted, mem_req_valid follows a_valid. mem_req_addr, mem_req_data and mem_req_mask equal a_address, a_data and a_mask. mem_req_write is 1 for PutFullData (a_opcode 0) and 0 for Get (a_opcode 4).
- R2: a_ready is high only when mem_req_ready is high, the tag queue is not full, and, for a Get, a read credit is free. A request is accepted on a cycle where a_valid and a_ready are both high.
- R3: At most RDQ_DEPTH reads may be accepted and not yet answered on D. A Get beyond that limit sees a_ready low, so no memory response can ever arrive while the read-data buffer is full.
- R4: An accepted write is answered with d_opcode 0 (AccessAck), its own source and size, and d_data zero. The earliest answer is the cycle after acceptance.
- R5: An accepted read is answered with d_opcode 1 (AccessAckData), its own source and size, and d_data equal to the memory response data. The earliest answer is the cycle after that data arrives.
- R6: D-channel responses leave in exactly the order the requests were accepted, with reads and writes mixed in one order.
- R7: While d_valid is high and d_ready is low, d_valid stays high and d_opcode, d_source, d_size and d_data hold their values.
- R8: d_denied and d_corrupt are always 0, b_valid is always 0, and c_ready and e_ready are always 1.
- R9: While rst is high, a_ready, d_valid and mem_req_valid are low. After reset no response from before the reset is issued.
- R10: At most OQ_DEPTH responses may be pending. With the tag queue full, a_ready is low even if a response leaves on the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| a_valid | input | 1 | A-channel request valid |
| a_ready | output | 1 | A-channel request accepted |
| a_opcode | input | 3 | 0 PutFullData, 4 Get |
| a_size | input | 3 | Log2 of transfer bytes |
| a_source | input | 6 | Requester source ID |
| a_address | input | ADDR_W (28) | Beat-relative byte address |
| a_mask | input | DATA_W/8 (32) | Active byte lanes |
| a_data | input | DATA_W (256) | Write data |
| d_valid | output | 1 | D-channel response valid |
| d_ready | input | 1 | D-channel response taken |
| d_opcode | output | 3 | 0 AccessAck, 1 AccessAckData |
| d_size | output | 3 | Size echoed from request |
| d_source | output | 6 | Source echoed from request |
| d_denied | output | 1 | Always 0 |
| d_corrupt | output | 1 | Always 0 |
| d_data | output | DATA_W (256) | Read data, zero for writes |
| b_valid | output | 1 | Unused B channel, tied 0 |
| c_ready | output | 1 | Unused C channel, tied 1 |
| e_ready | output | 1 | Unused E channel, tied 1 |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory request accepted |
| mem_req_write | output | 1 | 1 write, 0 read |
| mem_req_addr | output | ADDR_W (28) | Memory address |
| mem_req_data | output | DATA_W (256) | Memory write data |
| mem_req_mask | output | DATA_W/8 (32) | Memory byte mask |
| mem_rsp_valid | input | 1 | Read data valid, cannot be stalled |
| mem_rsp_data | input | DATA_W (256) | Read data |

## Verification
The assertions take several things for granted about the memory and the requester. The memory returns exactly one response for each read it accepted, in acceptance order, at most one per cycle, and never during or before the read's acceptance. It drops anything in flight across a reset. The requester holds A-channel fields steady while a_valid waits for a_ready, and uses only opcodes 0 and 4. The stimulus keeps to these rules through a behavioural memory model in the bench. It answers reads from an ordered list with random latency pushed to distinct cycles, and clears that list on reset. A-channel requests are re-randomised only after acceptance or while a_valid is low.

// File: rtl/tlmb_pkg.sv
package tlmb_pkg;
  localparam int SRC_W  = 6;
  localparam int SIZE_W = 3;

  localparam logic [2:0] A_PUT_FULL  = 3'd0;
  localparam logic [2:0] A_GET       = 3'd4;
  localparam logic [2:0] D_ACK       = 3'd0;
  localparam logic [2:0] D_ACK_DATA  = 3'd1;

  typedef struct packed {
    logic              is_read;
    logic [SRC_W-1:0]  source;
    logic [SIZE_W-1:0] size;
  } resp_tag_t;
endpackage

// File: rtl/tlmb_fifo.sv
module tlmb_fifo #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push,
  input  logic [WIDTH-1:0] push_data,
  input  logic             pop,
  output logic [WIDTH-1:0] head,
  output logic             empty,
  output logic             full
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

  logic [WIDTH-1:0] store [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic [CNT_W-1:0] level;

  always_ff @(posedge clk) begin
    if (push) store[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      level  <= '0;
    end else begin
      if (push) wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
      if (pop)  rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
      case ({push, pop})
        2'b10:   level <= level + 1'b1;
        2'b01:   level <= level - 1'b1;
        default: level <= level;
      endcase
    end
  end

  assign head  = store[rd_ptr];
  assign empty = (level == '0);
  assign full  = (level == CNT_W'(DEPTH));
endmodule

// File: rtl/tlmb_credit.sv
module tlmb_credit #(
  parameter int LIMIT = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic take,
  input  logic give,
  output logic avail
);
  localparam int CNT_W = $clog2(LIMIT + 1);

  logic [CNT_W-1:0] used;

  always_ff @(posedge clk) begin
    if (rst) begin
      used <= '0;
    end else begin
      case ({take, give})
        2'b10:   used <= used + 1'b1;
        2'b01:   used <= used - 1'b1;
        default: used <= used;
      endcase
    end
  end

  assign avail = (used < CNT_W'(LIMIT));
endmodule

// File: rtl/tl_mem_bridge.sv
module tl_mem_bridge
  import tlmb_pkg::*;
#(
  parameter int ADDR_W    = 28,
  parameter int DATA_W    = 256,
  parameter int OQ_DEPTH  = 4,
  parameter int RDQ_DEPTH = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                a_valid,
  output logic                a_ready,
  input  logic [2:0]          a_opcode,
  input  logic [SIZE_W-1:0]   a_size,
  input  logic [SRC_W-1:0]    a_source,
  input  logic [ADDR_W-1:0]   a_address,
  input  logic [DATA_W/8-1:0] a_mask,
  input  logic [DATA_W-1:0]   a_data,
  output logic                d_valid,
  input  logic                d_ready,
  output logic [2:0]          d_opcode,
  output logic [SIZE_W-1:0]   d_size,
  output logic [SRC_W-1:0]    d_source,
  output logic                d_denied,
  output logic                d_corrupt,
  output logic [DATA_W-1:0]   d_data,
  output logic                b_valid,
  output logic                c_ready,
  output logic                e_ready,
  output logic                mem_req_valid,
  input  logic                mem_req_ready,
  output logic                mem_req_write,
  output logic [ADDR_W-1:0]   mem_req_addr,
  output logic [DATA_W-1:0]   mem_req_data,
  output logic [DATA_W/8-1:0] mem_req_mask,
  input  logic                mem_rsp_valid,
  input  logic [DATA_W-1:0]   mem_rsp_data
);
  localparam int TAG_W = $bits(resp_tag_t);

  logic              a_is_read;
  logic              rd_avail;
  logic              admit;
  logic              a_fire;
  logic              d_fire;
  logic              oq_full, oq_empty;
  logic [TAG_W-1:0]  oq_head_bits;
  resp_tag_t         oq_head;
  resp_tag_t         oq_in;
  logic              rdq_full, rdq_empty;
  logic              rdq_push, rdq_pop;
  logic [DATA_W-1:0] rdq_head;
  logic              head_ok;

  // request admission
  assign a_is_read = (a_opcode == A_GET);
  assign admit     = !rst && !oq_full && (!a_is_read || rd_avail);
  assign mem_req_valid = a_valid && admit;
  assign a_ready   = admit && mem_req_ready;
  assign a_fire    = a_valid && a_ready;

  assign mem_req_write = !a_is_read;
  assign mem_req_addr  = a_address;
  assign mem_req_data  = a_data;
  assign mem_req_mask  = a_mask;

  // ordered response tags
  assign oq_in.is_read = a_is_read;
  assign oq_in.source  = a_source;
  assign oq_in.size    = a_size;

  tlmb_fifo #(.WIDTH(TAG_W), .DEPTH(OQ_DEPTH)) u_tag_q (
    .clk       (clk),
    .rst       (rst),
    .push      (a_fire),
    .push_data (oq_in),
    .pop       (d_fire),
    .head      (oq_head_bits),
    .empty     (oq_empty),
    .full      (oq_full)
  );
  assign oq_head = oq_head_bits;

  // unstallable read data lands here
  assign rdq_push = mem_rsp_valid && !rst;
  assign rdq_pop  = d_fire && oq_head.is_read;

  tlmb_fifo #(.WIDTH(DATA_W), .DEPTH(RDQ_DEPTH)) u_rdata_q (
    .clk       (clk),
    .rst       (rst),
    .push      (rdq_push),
    .push_data (mem_rsp_data),
    .pop       (rdq_pop),
    .head      (rdq_head),
    .empty     (rdq_empty),
    .full      (rdq_full)
  );

  // reads in flight or buffered
  tlmb_credit #(.LIMIT(RDQ_DEPTH)) u_rd_credit (
    .clk   (clk),
    .rst   (rst),
    .take  (a_fire && a_is_read),
    .give  (rdq_pop),
    .avail (rd_avail)
  );

  // response issue
  assign head_ok  = !oq_empty && (!oq_head.is_read || !rdq_empty);
  assign d_valid  = !rst && head_ok;
  assign d_fire   = d_valid && d_ready;
  assign d_opcode = oq_head.is_read ? D_ACK_DATA : D_ACK;
  assign d_source = oq_head.source;
  assign d_size   = oq_head.size;
  assign d_data   = oq_head.is_read ? rdq_head : '0;
  assign d_denied  = 1'b0;
  assign d_corrupt = 1'b0;

  assign b_valid = 1'b0;
  assign c_ready = 1'b1;
  assign e_ready = 1'b1;
endmodule

// File: rtl/tlmb_checker.sv
module tlmb_checker #(
  parameter int DATA_W = 256
) (
  input logic              clk,
  input logic              rst,
  input logic              a_valid,
  input logic              a_ready,
  input logic              mem_req_ready,
  input logic              mem_req_valid,
  input logic              d_valid,
  input logic              d_ready,
  input logic [2:0]        d_opcode,
  input logic [5:0]        d_source,
  input logic [2:0]        d_size,
  input logic [DATA_W-1:0] d_data,
  input logic              mem_rsp_valid,
  input logic              rdq_full
);
  assert_accept_is_issued_R1: assert property (@(posedge clk) disable iff (rst)
    (a_valid && a_ready) |-> mem_req_valid);

  assert_ready_needs_mem_R2: assert property (@(posedge clk) disable iff (rst)
    a_ready |-> mem_req_ready);

  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (rst)
    mem_rsp_valid |-> !rdq_full);

  assert_d_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (d_valid && !d_ready) |=> (d_valid && $stable(d_opcode) && $stable(d_source)
                               && $stable(d_size) && $stable(d_data)));

  assert_quiet_in_reset_R9: assert property (@(posedge clk)
    rst |-> (!a_ready && !d_valid && !mem_req_valid));
endmodule

bind tl_mem_bridge tlmb_checker #(.DATA_W(DATA_W)) u_chk (
  .clk           (clk),
  .rst           (rst),
  .a_valid       (a_valid),
  .a_ready       (a_ready),
  .mem_req_ready (mem_req_ready),
  .mem_req_valid (mem_req_valid),
  .d_valid       (d_valid),
  .d_ready       (d_ready),
  .d_opcode      (d_opcode),
  .d_source      (d_source),
  .d_size        (d_size),
  .d_data        (d_data),
  .mem_rsp_valid (mem_rsp_valid),
  .rdq_full      (rdq_full)
);

// File: tb/test_tl_mem_bridge.sv
`timescale 1ns/1ps
module test_tl_mem_bridge;
  localparam int OQ  = 4;
  localparam int RDQ = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic a_valid = 1'b0, d_ready = 1'b0, mem_req_ready = 1'b0, mem_rsp_valid = 1'b0;
  logic [2:0] a_opcode = '0, a_size = '0;
  logic [5:0] a_source = '0;
  logic [27:0] a_address = '0;
  logic [31:0] a_mask = '0;
  logic [255:0] a_data = '0, mem_rsp_data = '0;
  logic a_ready, d_valid, d_denied, d_corrupt, b_valid, c_ready, e_ready;
  logic mem_req_valid, mem_req_write;
  logic [2:0] d_opcode, d_size;
  logic [5:0] d_source;
  logic [255:0] d_data, mem_req_data;
  logic [27:0] mem_req_addr;
  logic [31:0] mem_req_mask;

  tl_mem_bridge i_tl_mem_bridge (
    .clk(clk), .rst(rst), .a_valid(a_valid), .a_ready(a_ready), .a_opcode(a_opcode),
    .a_size(a_size), .a_source(a_source), .a_address(a_address), .a_mask(a_mask),
    .a_data(a_data), .d_valid(d_valid), .d_ready(d_ready), .d_opcode(d_opcode),
    .d_size(d_size), .d_source(d_source), .d_denied(d_denied), .d_corrupt(d_corrupt),
    .d_data(d_data), .b_valid(b_valid), .c_ready(c_ready), .e_ready(e_ready),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_write(mem_req_write), .mem_req_addr(mem_req_addr),
    .mem_req_data(mem_req_data), .mem_req_mask(mem_req_mask),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data));

  always #2 clk = ~clk;

  int n_cmp = 0, n_bad = 0, cyc = 0;
  bit done = 1'b0;

  // reference model state: tag = {is_read, source, size}
  logic [9:0]   m_oq[$];
  logic [255:0] m_rdq[$];
  int           m_outst = 0;
  logic [255:0] pend_data[$];
  int           pend_due[$];
  int           last_due = 0;
  bit           prev_af = 1'b0;
  bit           prev_hold = 1'b0;
  logic [264:0] prev_d;

  int pv, prd, pdr, pmr;

  task automatic chk(input string tag, input logic [255:0] act, input logic [255:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s cycle %0d actual=%0h expected=%0h", tag, cyc, act, exp);
    end
  endtask

  task automatic new_req();
    a_valid  = ($urandom_range(99) < pv);
    a_opcode = ($urandom_range(99) < prd) ? 3'd4 : 3'd0;
    a_size   = 3'($urandom_range(5));
    a_source = 6'($urandom);
    a_address = 28'($urandom);
    a_mask   = $urandom;
    for (int k = 0; k < 8; k++) a_data[k*32 +: 32] = $urandom;
  endtask

  task automatic step(input bit r);
    bit rd, adm, e_ar, e_mrv, e_dv, af, df, hrd, rsp;
    logic [255:0] rdat;
    @(negedge clk);
    rst = r;
    if (r) a_valid = 1'b0;
    else if (!(a_valid && !prev_af)) new_req();
    d_ready       = ($urandom_range(99) < pdr);
    mem_req_ready = ($urandom_range(99) < pmr);
    rsp = !r && pend_due.size() > 0 && pend_due[0] <= cyc;
    mem_rsp_valid = rsp;
    mem_rsp_data  = rsp ? pend_data[0] : 256'h0;
    #1;
    rd    = (a_opcode == 3'd4);
    adm   = !r && m_oq.size() < OQ && (!rd || m_outst < RDQ);
    e_mrv = a_valid && adm;
    e_ar  = adm && mem_req_ready;
    hrd   = (m_oq.size() > 0) ? m_oq[0][9] : 1'b0;
    e_dv  = !r && m_oq.size() > 0 && (!hrd || m_rdq.size() > 0);

    if (r) chk("R9 quiet in reset", {a_ready, d_valid, mem_req_valid}, 3'b000);
    chk("R2 a_ready", a_ready, e_ar);
    chk("R1 mem_req_valid", mem_req_valid, e_mrv);
    if (e_mrv) begin
      chk("R1 addr", mem_req_addr, a_address);
      chk("R1 data", mem_req_data, a_data);
      chk("R1 mask", mem_req_mask, a_mask);
      chk("R1 write type", mem_req_write, !rd);
    end
    if (!r && a_valid && rd && m_outst >= RDQ) chk("R3 read credit exhausted", a_ready, 1'b0);
    if (!r && m_oq.size() == OQ) chk("R10 tag queue full", a_ready, 1'b0);
    chk("R6 d_valid", d_valid, e_dv);
    if (e_dv) begin
      chk("R6 order source", d_source, m_oq[0][8:3]);
      chk("R6 order size", d_size, m_oq[0][2:0]);
      if (hrd) begin
        chk("R5 opcode AccessAckData", d_opcode, 3'd1);
        chk("R5 read data", d_data, m_rdq[0]);
      end else begin
        chk("R4 opcode AccessAck", d_opcode, 3'd0);
        chk("R4 zero data", d_data, 256'h0);
      end
    end
    if (prev_hold && !r) chk("R7 held response", {d_valid, d_opcode, d_source, d_size, d_data}, prev_d);
    chk("R8 denied corrupt", {d_denied, d_corrupt}, 2'b00);
    chk("R8 tie-offs", {b_valid, c_ready, e_ready}, 3'b011);

    af = a_valid && e_ar;
    df = e_dv && d_ready;
    prev_hold = e_dv && !d_ready;
    prev_d = {d_valid, d_opcode, d_source, d_size, d_data};
    @(posedge clk);
    if (r) begin
      m_oq.delete(); m_rdq.delete(); pend_data.delete(); pend_due.delete();
      m_outst = 0; prev_hold = 1'b0; last_due = cyc;
    end else begin
      if (rsp) begin
        m_rdq.push_back(pend_data.pop_front());
        void'(pend_due.pop_front());
      end
      if (df) begin
        if (hrd) begin void'(m_rdq.pop_front()); m_outst--; end
        void'(m_oq.pop_front());
      end
      if (af) begin
        m_oq.push_back({rd, a_source, a_size});
        if (rd) begin
          int due;
          m_outst++;
          for (int k = 0; k < 8; k++) rdat[k*32 +: 32] = $urandom;
          due = cyc + 1 + $urandom_range(7);
          if (due <= last_due) due = last_due + 1;
          last_due = due;
          pend_data.push_back(rdat);
          pend_due.push_back(due);
        end
      end
    end
    prev_af = af;
    cyc++;
  endtask

  task automatic run(input int n, input int v, input int rdp, input int dr, input int mr);
    pv = v; prd = rdp; pdr = dr; pmr = mr;
    for (int i = 0; i < n; i++) step(1'b0);
  endtask

  initial begin
    pv = 0; prd = 0; pdr = 100; pmr = 100;
    for (int i = 0; i < 3; i++) step(1'b1);      // R9 reset state
    run(40, 80, 0, 100, 100);                      // R4 writes only
    run(60, 80, 100, 100, 100);                    // R5 reads only
    run(20, 100, 50, 0, 100);                      // R10, R3 fill with D stalled
    run(30, 0, 0, 100, 100);                       // drain
    run(2000, 70, 50, 60, 70);                     // R6, R7, R2 mixed
    run(10, 100, 50, 0, 100);
    for (int i = 0; i < 2; i++) step(1'b1);      // R9 reset with work pending
    run(200, 70, 50, 60, 70);
    run(50, 0, 0, 100, 100);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired at cycle %0d", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule